// File: doc/BRIEF.md
# Four-Level Address Strap Decoder

This block works out how each of two address strap pins is wired. A pin can be tied to ground, to supply, to the serial clock line or to the serial data line. It finds the wiring by comparing each pin, cycle by cycle, with the bus clock and data levels while a transfer is in progress. It does this for every transfer on the bus, whichever device that transfer addresses. At the end of each transfer window it commits a strap class for each pin. From the two classes it forms a 4-bit slave address nibble, two input pullup group enables and the power-up default pattern for eight push-pull outputs.

The block needs the following inputs, already synchronized to `clk`:
- the strap pin levels;
- the bus line levels;
- single-cycle START, STOP and address-acknowledge indications from a bus front end.

Before the first transfer window is committed, each pin is classed by its static level. The bus idles high, so a pin strapped to a bus line reads as tied to supply until a real transfer has been seen.

Top module: `adp_addr_decoder`

## Requirements
- R1: Pin A sets address bits [1:0]: ground gives 00, supply gives 01, SCL gives 10, SDA gives 11.
- R2: Pin B sets address bits [3:2]: SCL gives 00, SDA gives 01, ground gives 10, supply gives 11.
- R3: Until the first commit, each pin is classed every cycle by its level: low is ground, high is supply. A bus-tied pin on an idle bus therefore reads as supply. The result shows one cycle after the level is sampled.
- R4: A pin that equals SCL at every cycle of a transfer window, and is not constant over that window, is classed as SCL.
- R5: A pin that equals SDA at every cycle of a transfer window, is not constant over it, and does not equal SCL throughout, is classed as SDA.
- R6: A pin that is constant over the whole window is classed by that level, ground or supply, ahead of any match with a bus line.
- R7: A window opens on a START pulse, and a repeated START reopens it. The window commits on a STOP pulse or on an address-acknowledge pulse, and the outputs change in the cycle after that pulse. The outputs do not change at any other time. A STOP or acknowledge pulse with no window open has no effect.
- R8: If a pin is not constant and matches neither SCL nor SDA over the window, its previous class is kept.
- R9: `pu_en[0]` (the group for inputs 0-3) follows pin A and `pu_en[1]` (the group for inputs 4-7) follows pin B. Each enable is 0 when its pin is classed ground and 1 for any other class.
- R10: `out_dflt[3:0]` (outputs 8-11) is all zeros when pin A is classed ground and all ones otherwise. `out_dflt[7:4]` (outputs 12-15) follows pin B in the same way.
- R11: While reset is held, both pins are classed supply: `addr_nib`=1101, `pu_en`=11, `out_dflt`=FF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_a | input | 1 | Synchronized level of strap pin A (low address pair) |
| pin_b | input | 1 | Synchronized level of strap pin B (high address pair) |
| scl_in | input | 1 | Synchronized bus clock level |
| sda_in | input | 1 | Synchronized bus data level |
| start_det | input | 1 | One-cycle START or repeated START indication |
| stop_det | input | 1 | One-cycle STOP indication |
| ack_det | input | 1 | One-cycle address-acknowledge indication |
| addr_nib | output | 4 | Decoded slave address bits [3:0] |
| pu_en | output | 2 | Pullup enables for input groups 0-3 and 4-7 |
| out_dflt | output | 2*GROUP_W | Power-up default levels for the push-pull outputs |

## Verification
A wrong strap class appears on all three outputs one cycle after the commit pulse. The address pair takes a wrong code, and the pullup enable and output defaults for that pin flip whenever the error crosses the ground/non-ground line. A stuck window tracker shows up in a different way: either the outputs fail to follow the new strapping at the next STOP or acknowledge, or they change when a STOP arrives with no window open. A mishandled pre-commit state is visible straight after reset: a bus-tied or grounded pin then reads as the wrong level before any transfer has happened.

// File: rtl/adp_pkg.sv
package adp_pkg;

   typedef enum logic [1:0] {
      STRAP_GND = 2'd0,
      STRAP_VDD = 2'd1,
      STRAP_SCL = 2'd2,
      STRAP_SDA = 2'd3
   } strap_e;

   // Low pair takes the class code as is; high pair swaps the rail and bus halves.
   function automatic logic [1:0] strap_pair(input strap_e s, input bit is_upper);
      logic [1:0] code;
      code = s;
      return is_upper ? (code ^ 2'b10) : code;
   endfunction

endpackage

// File: rtl/adp_pin_tracker.sv
module adp_pin_tracker
   import adp_pkg::*;
#(
   parameter bit COMMIT_ON_ACK = 1'b1
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   pin,
   input  logic   scl_in,
   input  logic   sda_in,
   input  logic   start_det,
   input  logic   stop_det,
   input  logic   ack_det,
   output strap_e strap,
   output logic   seen
);

   logic   active_q;
   logic   acc_scl_q, acc_sda_q, acc_hi_q, acc_lo_q;
   logic   cur_scl, cur_sda;
   logic   eff_scl, eff_sda, eff_hi, eff_lo;
   logic   commit_ev, commit;
   strap_e strap_q;

   assign cur_scl = (pin == scl_in);
   assign cur_sda = (pin == sda_in);

   // Window results including the sample taken in the commit cycle.
   assign eff_scl = acc_scl_q & cur_scl;
   assign eff_sda = acc_sda_q & cur_sda;
   assign eff_hi  = acc_hi_q  & pin;
   assign eff_lo  = acc_lo_q  & ~pin;

   generate
      if (COMMIT_ON_ACK) begin : g_commit_ack
         assign commit_ev = stop_det | ack_det;
      end else begin : g_commit_stop
         logic unused_ack;
         assign unused_ack = ack_det;
         assign commit_ev  = stop_det;
      end
   endgenerate

   assign commit = active_q & commit_ev & ~start_det;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q  <= 1'b0;
         acc_scl_q <= 1'b0;
         acc_sda_q <= 1'b0;
         acc_hi_q  <= 1'b0;
         acc_lo_q  <= 1'b0;
      end else if (start_det) begin
         active_q  <= 1'b1;
         acc_scl_q <= cur_scl;
         acc_sda_q <= cur_sda;
         acc_hi_q  <= pin;
         acc_lo_q  <= ~pin;
      end else if (commit) begin
         active_q  <= 1'b0;
      end else if (active_q) begin
         acc_scl_q <= eff_scl;
         acc_sda_q <= eff_sda;
         acc_hi_q  <= eff_hi;
         acc_lo_q  <= eff_lo;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strap_q <= STRAP_VDD;
         seen    <= 1'b0;
      end else if (commit) begin
         seen <= 1'b1;
         if (eff_lo)       strap_q <= STRAP_GND;
         else if (eff_hi)  strap_q <= STRAP_VDD;
         else if (eff_scl) strap_q <= STRAP_SCL;
         else if (eff_sda) strap_q <= STRAP_SDA;
      end else if (!seen) begin
         strap_q <= pin ? STRAP_VDD : STRAP_GND;
      end
   end

   assign strap = strap_q;

endmodule

// File: rtl/adp_strap_map.sv
module adp_strap_map
   import adp_pkg::*;
#(
   parameter bit IS_UPPER = 1'b0,
   parameter int GROUP_W  = 4
) (
   input  strap_e             strap,
   output logic [1:0]         pair,
   output logic               pu,
   output logic [GROUP_W-1:0] dflt
);

   logic not_gnd;

   assign not_gnd = (strap != STRAP_GND);
   assign pair    = strap_pair(strap, IS_UPPER);
   assign pu      = not_gnd;
   assign dflt    = {GROUP_W{not_gnd}};

endmodule

// File: rtl/adp_addr_decoder.sv
module adp_addr_decoder
   import adp_pkg::*;
#(
   parameter int GROUP_W       = 4,
   parameter bit COMMIT_ON_ACK = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 pin_a,
   input  logic                 pin_b,
   input  logic                 scl_in,
   input  logic                 sda_in,
   input  logic                 start_det,
   input  logic                 stop_det,
   input  logic                 ack_det,
   output logic [3:0]           addr_nib,
   output logic [1:0]           pu_en,
   output logic [2*GROUP_W-1:0] out_dflt
);

   localparam int NPINS  = 2;
   localparam int PAIR_W = 2;

   generate
      if (GROUP_W < 1) begin : g_bad_group
         $error("adp_addr_decoder: GROUP_W must be at least 1");
      end
   endgenerate

   logic [NPINS-1:0] pin_vec;
   logic [NPINS-1:0] seen_vec;
   strap_e           strap_vec [NPINS];

   assign pin_vec = {pin_b, pin_a};

   genvar g;
   generate
      for (g = 0; g < NPINS; g++) begin : g_pin
         adp_pin_tracker #(
            .COMMIT_ON_ACK(COMMIT_ON_ACK)
         ) u_trk (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin      (pin_vec[g]),
            .scl_in   (scl_in),
            .sda_in   (sda_in),
            .start_det(start_det),
            .stop_det (stop_det),
            .ack_det  (ack_det),
            .strap    (strap_vec[g]),
            .seen     (seen_vec[g])
         );

         adp_strap_map #(
            .IS_UPPER(g == 1),
            .GROUP_W (GROUP_W)
         ) u_map (
            .strap(strap_vec[g]),
            .pair (addr_nib[g*PAIR_W +: PAIR_W]),
            .pu   (pu_en[g]),
            .dflt (out_dflt[g*GROUP_W +: GROUP_W])
         );
      end
   endgenerate

endmodule

// File: rtl/adp_addr_decoder_chk.sv
module adp_addr_decoder_chk #(
   parameter int GROUP_W = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 stop_det,
   input logic                 ack_det,
   input logic [1:0]           seen,
   input logic [3:0]           addr_nib,
   input logic [1:0]           pu_en,
   input logic [2*GROUP_W-1:0] out_dflt
);

   // R3: before the first commit only the rail classes can appear.
   p_pre_first_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !seen[0] |-> (addr_nib[1] == 1'b0));
   p_pre_first_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !seen[1] |-> (addr_nib[3] == 1'b1));

   // R7: once committed, the nibble only moves after a STOP or acknowledge.
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((seen == 2'b11) && ($past(seen) == 2'b11) && !$past(stop_det) && !$past(ack_det))
      |-> $stable(addr_nib));

   // R9: a pullup group is off exactly when its pair holds the ground code.
   p_pullup_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pu_en[0] == (addr_nib[1:0] != 2'b00)) && (pu_en[1] == (addr_nib[3:2] != 2'b10)));

   // R10: each default group matches its pullup enable.
   p_dflt_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_dflt[GROUP_W-1:0] == {GROUP_W{pu_en[0]}}) &&
      (out_dflt[2*GROUP_W-1:GROUP_W] == {GROUP_W{pu_en[1]}}));

endmodule

bind adp_addr_decoder adp_addr_decoder_chk #(.GROUP_W(GROUP_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .stop_det(stop_det),
   .ack_det (ack_det),
   .seen    (seen_vec),
   .addr_nib(addr_nib),
   .pu_en   (pu_en),
   .out_dflt(out_dflt)
);

// File: tb/adp_addr_decoder_bench.sv
`timescale 1ns/1ps
module adp_addr_decoder_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl = 1'b1, sda = 1'b1;
   logic       start_det = 1'b0, stop_det = 1'b0, ack_det = 1'b0;
   int         mode_a = 1, mode_b = 1;   // 0 gnd, 1 vdd, 2 scl, 3 sda, 4 inconsistent
   logic       pin_a, pin_b;
   logic [3:0] addr_nib;
   logic [1:0] pu_en;
   logic [7:0] out_dflt;

   int n_checks = 0, n_fail = 0;
   int cls_a = 1, cls_b = 1;
   logic [13:0] exp_q [$];
   string       tag_q [$];
   bit          pend = 1'b0;

   always #4 clk = ~clk;

   function automatic logic pin_level(input int m, input logic c, input logic d);
      case (m)
         0: return 1'b0;
         1: return 1'b1;
         2: return c;
         3: return d;
         default: return ~c;
      endcase
   endfunction

   assign pin_a = pin_level(mode_a, scl, sda);
   assign pin_b = pin_level(mode_b, scl, sda);

   adp_addr_decoder u_adp_addr_decoder (
      .clk(clk), .rst_n(rst_n), .pin_a(pin_a), .pin_b(pin_b),
      .scl_in(scl), .sda_in(sda), .start_det(start_det),
      .stop_det(stop_det), .ack_det(ack_det),
      .addr_nib(addr_nib), .pu_en(pu_en), .out_dflt(out_dflt));

   // R1 table for pin A, R2 table for pin B.
   function automatic logic [1:0] low_code(input int c);
      case (c) 0: return 2'b00; 1: return 2'b01; 2: return 2'b10; default: return 2'b11; endcase
   endfunction
   function automatic logic [1:0] high_code(input int c);
      case (c) 2: return 2'b00; 3: return 2'b01; 0: return 2'b10; default: return 2'b11; endcase
   endfunction
   function automatic logic [13:0] expect_vec(input int ca, input int cb);
      logic pa, pb;
      pa = (ca != 0);
      pb = (cb != 0);
      return {high_code(cb), low_code(ca), pb, pa, {4{pb}}, {4{pa}}};
   endfunction

   task automatic check_now(input string tag, input logic [13:0] exp);
      logic [13:0] act;
      act = {addr_nib, pu_en, out_dflt};
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual nib=%b pu=%b dflt=%h expected nib=%b pu=%b dflt=%h",
                  tag, act[13:10], act[9:8], act[7:0], exp[13:10], exp[9:8], exp[7:0]);
      end
   endtask

   task automatic push_exp(input string tag);
      exp_q.push_back(expect_vec(cls_a, cls_b));
      tag_q.push_back(tag);
   endtask

   // Monitor: a STOP or ack seen after one negedge is checked after the next.
   initial begin
      forever begin
         @(negedge clk); #1;
         if (pend) begin
            if (exp_q.size() == 0) begin
               n_checks++; n_fail++;
               $display("FAIL R7: commit with no expected item, actual nib=%b expected none", addr_nib);
            end else begin
               check_now(tag_q.pop_front(), exp_q.pop_front());
            end
         end
         pend = stop_det | ack_det;
      end
   end

   // Driver: one transfer window with the given strapping.
   task automatic run_txn(input int ma, input int mb, input bit use_stop,
                          input bit do_commit, input string tag);
      logic [8:0] bits;
      bits = 9'b101100100;
      @(negedge clk); mode_a = ma; mode_b = mb; scl = 1; sda = 1;
      @(negedge clk); sda = 0; start_det = 1;
      @(negedge clk); start_det = 0; scl = 0;
      for (int i = 0; i < 9; i++) begin
         @(negedge clk); scl = 0; sda = bits[i];
         @(negedge clk); scl = 1;
      end
      if (!do_commit) return;
      if (ma < 4) cls_a = ma;
      if (mb < 4) cls_b = mb;
      if (use_stop) begin
         @(negedge clk); scl = 0; sda = 0;
         @(negedge clk); scl = 1;
         @(negedge clk); sda = 1; push_exp(tag); stop_det = 1;
         @(negedge clk); stop_det = 0;
      end else begin
         @(negedge clk); push_exp(tag); ack_det = 1;
         @(negedge clk); ack_det = 0; scl = 0;
         @(negedge clk); scl = 1; sda = 0;
         // R7: a STOP after the ack has no window open and changes nothing.
         @(negedge clk); sda = 1; push_exp("R7 stop after ack"); stop_det = 1;
         @(negedge clk); stop_det = 0;
      end
      repeat (2) @(negedge clk);
   endtask

   initial begin
      // R11: reset state, with pin A grounded and pin B strapped to SCL.
      mode_a = 0; mode_b = 2;
      repeat (3) @(negedge clk);
      #1 check_now("R11 reset", 14'b1101_11_11111111);
      @(negedge clk); rst_n = 1;
      repeat (2) @(negedge clk);
      #1 check_now("R3 pre-commit gnd/bus-idle", expect_vec(0, 1));
      mode_a = 3;
      repeat (2) @(negedge clk);
      #1 check_now("R3 pre-commit sda idle high", expect_vec(1, 1));
      cls_a = 1; cls_b = 1;

      // R1 R2 R4 R5 R6 R9 R10: every strapping pair, alternating commit kinds.
      for (int a = 0; a < 4; a++)
         for (int b = 0; b < 4; b++)
            run_txn(a, b, (a + b) % 2 == 0, 1'b1, $sformatf("R1/R2 map a=%0d b=%0d", a, b));

      run_txn(2, 0, 1'b0, 1'b1, "R4 scl on A");
      run_txn(3, 3, 1'b1, 1'b1, "R5 sda on both");
      run_txn(1, 0, 1'b1, 1'b1, "R6 static rails");

      // R8: inconsistent pin keeps its previous class.
      run_txn(4, 3, 1'b0, 1'b1, "R8 A inconsistent");
      run_txn(2, 4, 1'b1, 1'b1, "R8 B inconsistent");

      // R7: open window with new strapping but no commit leaves outputs unchanged.
      run_txn(0, 1, 1'b1, 1'b0, "R7");
      #1 check_now("R7 no change inside window", expect_vec(cls_a, cls_b));
      // R7: a repeated START reopens the window; then commit.
      run_txn(3, 2, 1'b1, 1'b1, "R7 repeated start commit");

      // R7: STOP with no open window and changed pins has no effect.
      @(negedge clk); mode_a = 0; mode_b = 0;
      @(negedge clk); push_exp("R7 idle stop"); stop_det = 1;
      @(negedge clk); stop_det = 0;
      repeat (3) @(negedge clk);
      #1 check_now("R9 R10 final hold", expect_vec(cls_a, cls_b));

      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      #200000;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule